// File: doc/BRIEF.md
# Lag-Gated Input Replay Queue

In a replicated pair of processors that run the same program, one copy leads and the other trails it by a fixed number of timestamp ticks. Each input that reaches the leading copy is stamped with the leader's timestamp counter. The pair of payload and stamp then goes to the trailing copy. There, this block holds the messages in arrival order. It releases each payload to the local core in the exact tick when the local timestamp counter reaches the stamp plus the configured lag. Both copies therefore consume every input at the same point in their execution.

The block has two parts. The stamping stage on the leader side takes the payload and the leader timestamp. The gated queue on the trailing side receives local time and drives the delivery strobe. The top module wires the two together, so one instance covers the whole path and can be exercised from its ports.

Release is not tied to ordinary FIFO readiness. The oldest entry leaves only when the local clock has come around to its due tick. A message that arrives with little slack raises a margin warning. A message that arrives after its due tick has already been reached sets a sticky error, which shows that the lag has collapsed.

Top module: `lag_gate_queue`

## Requirements
- R1: An input accepted on `src_valid`/`src_ready` is stamped with the `lead_ts` value of the accepting cycle. While the stamped message cannot enter the queue it is held unchanged. `src_ready` is low only when that stage is occupied and the queue can take nothing.
- R2: Messages leave in the order in which they were accepted.
- R3: The queue holds at most DEPTH messages. With DEPTH stored, `q_full` is high, `q_count` equals DEPTH and further input stalls.
- R4: The oldest stored message is presented on `dlv_valid`/`dlv_data` for exactly one cycle. That cycle is the one in which `local_ts` equals its stamp plus DELAY (mod 2^32), provided it was stored before that cycle. It is never presented earlier.
- R5: At most one message is delivered per cycle. A message that becomes due while an older one is still queued is delivered in the cycle after the older one leaves.
- R6: When a message enters the queue, its slack is its due tick minus `local_ts`, taken as a signed 32-bit difference. If the slack is below MARGIN, `margin_warn` is high for exactly the next cycle. Otherwise `margin_warn` stays low.
- R7: If the slack on entry is zero or negative, `lockstep_err` goes high in the next cycle and stays high until reset. Such a message is still delivered, once, as soon as it is the oldest entry.
- R8: Due ticks that wrap past 2^32-1 are handled: release happens at the wrapped tick, and neither flag is raised wrongly.
- R9: After reset the queue is empty (`q_empty` high, `q_count` 0, `q_full` low). `dlv_valid`, `margin_warn` and `lockstep_err` are low and `src_ready` is high.
- R10: When the queue is full and the oldest entry is released, a waiting message enters in the same cycle. `src_ready` is high in that cycle and `q_count` stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Leader-side input payload valid |
| src_ready | output | 1 | Leader-side input accepted this cycle when valid |
| src_data | input | DATA_W | Input payload |
| lead_ts | input | 32 | Leader timestamp counter |
| local_ts | input | 32 | Trailing-side timestamp counter |
| dlv_valid | output | 1 | Payload delivered to the local core this cycle |
| dlv_data | output | DATA_W | Delivered payload |
| q_count | output | $clog2(DEPTH+1) | Messages held in the queue |
| q_full | output | 1 | Queue holds DEPTH messages |
| q_empty | output | 1 | Queue holds nothing |
| margin_warn | output | 1 | One-cycle pulse: last arrival had less slack than MARGIN |
| lockstep_err | output | 1 | Sticky: a message arrived at or after its due tick |

## Verification
Two actions can fall in the same cycle: the release of the oldest entry and the entry of a new message. This is provoked by filling the queue with messages that are due far in the future and keeping one more waiting in the stamping stage. The local clock is then run to the first due tick. The outcome is judged at the ports. In that tick `src_ready` must rise together with `dlv_valid`, the count must still read DEPTH one cycle later, and the next payload must follow in order in the following tick. A second overlap, where a younger message falls due before an older one, checks that release stays strictly one per cycle and in order.

// File: rtl/gdq_pkg.sv
package gdq_pkg;

  localparam int unsigned TS_W = 32;

  typedef logic [TS_W-1:0] ts_t;

  typedef enum logic [1:0] {
    ARR_EARLY = 2'd0,
    ARR_TIGHT = 2'd1,
    ARR_LATE  = 2'd2
  } arr_class_e;

  // Tick on which a stamped message must be handed to the local core.
  function automatic ts_t due_of(input ts_t stamp, input ts_t lag);
    return stamp + lag;
  endfunction

  // Signed distance from 'earlier' to 'later' on the wrapping time line.
  function automatic logic signed [TS_W-1:0] ts_gap(input ts_t later, input ts_t earlier);
    return signed'(later - earlier);
  endfunction

  // True once 'now' has come to or past 'due'.
  function automatic logic ts_reached(input ts_t now, input ts_t due);
    return ts_gap(now, due) >= 0;
  endfunction

  // Classify an arrival by how much time is left before it falls due.
  function automatic arr_class_e classify(input ts_t now, input ts_t due, input ts_t margin);
    logic signed [TS_W-1:0] slack;
    slack = ts_gap(due, now);
    if (slack <= 0)                  return ARR_LATE;
    else if (slack < signed'(margin)) return ARR_TIGHT;
    else                             return ARR_EARLY;
  endfunction

endpackage

// File: rtl/gdq_stamper.sv
module gdq_stamper
  import gdq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  ts_t               lead_ts,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output ts_t               out_stamp
);

  logic              hold_q;
  logic [DATA_W-1:0] data_q;
  ts_t               stamp_q;
  logic              take;

  assign in_ready = !hold_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      data_q  <= '0;
      stamp_q <= '0;
    end else begin
      if (in_ready) hold_q <= in_valid;
      if (take) begin
        data_q  <= in_data;
        stamp_q <= lead_ts;
      end
    end
  end

  assign out_valid = hold_q;
  assign out_data  = data_q;
  assign out_stamp = stamp_q;

  // R1: a message refused downstream stays put with its stamp
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_stamp));

endmodule

// File: rtl/gdq_store.sv
module gdq_store
  import gdq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  ts_t               push_due,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output ts_t               head_due,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] slot_data [DEPTH];
  ts_t               slot_due  [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [DATA_W-1:0] d_q;
    ts_t               t_q;
    logic              wr_en;
    assign wr_en = push && (wr_ptr_q == PTR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        t_q <= '0;
      end else if (wr_en) begin
        d_q <= push_data;
        t_q <= push_due;
      end
    end
    assign slot_data[gi] = d_q;
    assign slot_due[gi]  = t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_data = slot_data[rd_ptr_q];
  assign head_due  = slot_due[rd_ptr_q];
  assign count     = count_q;
  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);

  // R2: release logic never drains an empty store
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R3: a write into a full store only happens alongside a release
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |-> pop);

  // R10: simultaneous entry and release leave the occupancy unchanged
  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> count == $past(count));

endmodule

// File: rtl/gdq_gate.sv
module gdq_gate
  import gdq_pkg::*;
#(
  parameter int unsigned DELAY  = 256,
  parameter int unsigned MARGIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_valid,
  input  ts_t  msg_stamp,
  output logic msg_ready,
  input  ts_t  local_ts,
  input  logic store_full,
  input  logic store_empty,
  input  ts_t  head_due,
  output logic push,
  output ts_t  push_due,
  output logic pop,
  output logic margin_warn,
  output logic lockstep_err
);

  arr_class_e arr_cls;
  logic       head_ripe;
  logic       warn_q;
  logic       err_q;

  assign push_due  = due_of(msg_stamp, ts_t'(DELAY));
  assign head_ripe = !store_empty && ts_reached(local_ts, head_due);
  assign pop       = head_ripe;
  assign msg_ready = !store_full || pop;
  assign push      = msg_valid && msg_ready;
  assign arr_cls   = classify(local_ts, push_due, ts_t'(MARGIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      warn_q <= push && (arr_cls != ARR_EARLY);
      err_q  <= err_q || (push && (arr_cls == ARR_LATE));
    end
  end

  assign margin_warn  = warn_q;
  assign lockstep_err = err_q;

  // R6: every warning pulse is caused by an arrival in the cycle before
  a_r6_warn_follows_push: assert property (@(posedge clk) disable iff (!rst_n)
    margin_warn |-> $past(push));

  // R7: the violation flag never clears by itself
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockstep_err |=> lockstep_err);

endmodule

// File: rtl/lag_gate_queue.sv
module lag_gate_queue
  import gdq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DELAY  = 256,
  parameter int unsigned MARGIN = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic [31:0]       lead_ts,
  input  logic [31:0]       local_ts,
  output logic              dlv_valid,
  output logic [DATA_W-1:0] dlv_data,
  output logic [CNT_W-1:0]  q_count,
  output logic              q_full,
  output logic              q_empty,
  output logic              margin_warn,
  output logic              lockstep_err
);

  logic              msg_valid, msg_ready;
  logic [DATA_W-1:0] msg_data;
  ts_t               msg_stamp;
  logic              push_w, pop_w;
  ts_t               push_due_w, head_due_w;
  logic [DATA_W-1:0] head_data_w;

  gdq_stamper #(.DATA_W(DATA_W)) u_stamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (src_valid),
    .in_ready  (src_ready),
    .in_data   (src_data),
    .lead_ts   (lead_ts),
    .out_valid (msg_valid),
    .out_ready (msg_ready),
    .out_data  (msg_data),
    .out_stamp (msg_stamp)
  );

  gdq_gate #(.DELAY(DELAY), .MARGIN(MARGIN)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .msg_valid    (msg_valid),
    .msg_stamp    (msg_stamp),
    .msg_ready    (msg_ready),
    .local_ts     (local_ts),
    .store_full   (q_full),
    .store_empty  (q_empty),
    .head_due     (head_due_w),
    .push         (push_w),
    .push_due     (push_due_w),
    .pop          (pop_w),
    .margin_warn  (margin_warn),
    .lockstep_err (lockstep_err)
  );

  gdq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_w),
    .push_data (msg_data),
    .push_due  (push_due_w),
    .pop       (pop_w),
    .head_data (head_data_w),
    .head_due  (head_due_w),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign dlv_valid = pop_w;
  assign dlv_data  = head_data_w;

  // R4: a delivery always removes one entry unless a new one replaces it
  a_r4_release_drains: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !push_w |=> q_count == $past(q_count) - 1'b1);

  // R4: nothing is delivered from an empty queue
  a_r4_release_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !q_empty);

  // R1: input stalls only because the queue has no room
  a_r1_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ready |-> q_full);

endmodule

// File: tb/lag_gate_queue_tb.sv
module lag_gate_queue_tb_top;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int DELAY  = 256;
  localparam int MARGIN = 32;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              src_valid = 1'b0;
  logic              src_ready;
  logic [DATA_W-1:0] src_data = '0;
  logic [31:0]       lead_ts, local_ts;
  logic              dlv_valid;
  logic [DATA_W-1:0] dlv_data;
  logic [CNT_W-1:0]  q_count;
  logic              q_full, q_empty, margin_warn, lockstep_err;

  logic [31:0] tick = '0;
  logic        tick_ld = 1'b0;
  logic [31:0] tick_val = '0;
  int          lead_off = 0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] dlv_tick [64];
  logic [31:0] dlv_dat  [64];
  logic [31:0] warn_tick [64];
  int n_dlv = 0;
  int n_warn = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tick <= tick_ld ? tick_val : tick + 32'd1;

  assign local_ts = tick;
  assign lead_ts  = tick + 32'(lead_off);

  lag_gate_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DELAY(DELAY), .MARGIN(MARGIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .lead_ts(lead_ts), .local_ts(local_ts),
    .dlv_valid(dlv_valid), .dlv_data(dlv_data), .q_count(q_count),
    .q_full(q_full), .q_empty(q_empty), .margin_warn(margin_warn),
    .lockstep_err(lockstep_err)
  );

  always @(negedge clk) begin
    if (rst_n && dlv_valid && n_dlv < 64) begin
      dlv_tick[n_dlv] = tick;
      dlv_dat[n_dlv]  = dlv_data;
      n_dlv++;
    end
    if (rst_n && margin_warn && n_warn < 64) begin
      warn_tick[n_warn] = tick;
      n_warn++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_tick(input logic [31:0] v);
    tick_ld = 1'b1;
    tick_val = v;
    @(negedge clk);
    tick_ld = 1'b0;
  endtask

  task automatic wait_tick(input logic [31:0] t);
    while (tick != t) @(negedge clk);
  endtask

  // Called at a negedge; returns the local tick at which the input was taken.
  task automatic send(input logic [31:0] d, output logic [31:0] cap);
    src_valid = 1'b1;
    src_data  = d;
    while (!src_ready) @(negedge clk);
    cap = tick;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk(q_count == 0, "R9", "q_count", 64'(q_count), 0);
    chk(q_empty == 1'b1, "R9", "q_empty", 64'(q_empty), 1);
    chk(q_full == 1'b0, "R9", "q_full", 64'(q_full), 0);
    chk(dlv_valid == 1'b0, "R9", "dlv_valid", 64'(dlv_valid), 0);
    chk(margin_warn == 1'b0, "R9", "margin_warn", 64'(margin_warn), 0);
    chk(lockstep_err == 1'b0, "R9", "lockstep_err", 64'(lockstep_err), 0);
    chk(src_ready == 1'b1, "R9", "src_ready", 64'(src_ready), 1);
  endtask

  // Single message with leader offset 'off'; slack on entry is off+255.
  task automatic one_shot(input int off, input logic [31:0] d, input bit exp_warn,
                          input bit exp_err, input string req);
    logic [31:0] cap, due, rel;
    int b_dlv, b_warn;
    do_reset();
    lead_off = off;
    b_dlv = n_dlv;
    b_warn = n_warn;
    send(d, cap);
    rel = ((off + DELAY) < 2) ? 32'd2 : 32'(off + DELAY);
    due = cap + rel;
    wait_tick(due + 32'd3);
    #1;
    chk(n_dlv - b_dlv == 1, req, "delivery count", 64'(n_dlv - b_dlv), 1);
    chk(dlv_tick[b_dlv] == due, req, "delivery tick", 64'(dlv_tick[b_dlv]), 64'(due));
    chk(dlv_dat[b_dlv] == d, req, "delivery data", 64'(dlv_dat[b_dlv]), 64'(d));
    chk((n_warn - b_warn) == int'(exp_warn), req, "warn pulses",
        64'(n_warn - b_warn), 64'(exp_warn));
    if (exp_warn)
      chk(warn_tick[b_warn] == cap + 32'd2, req, "warn tick",
          64'(warn_tick[b_warn]), 64'(cap + 32'd2));
    chk(lockstep_err == exp_err, req, "lockstep_err", 64'(lockstep_err), 64'(exp_err));
    @(negedge clk);
  endtask

  task automatic test_on_time();   one_shot(0,    32'hA5A5_0001, 1'b0, 1'b0, "R4"); endtask
  task automatic test_margin();    one_shot(-230, 32'hA5A5_0002, 1'b1, 1'b0, "R6"); endtask
  task automatic test_tight_edge(); one_shot(-254, 32'hA5A5_0003, 1'b1, 1'b0, "R6"); endtask
  task automatic test_late_edge(); one_shot(-255, 32'hA5A5_0004, 1'b1, 1'b1, "R7"); endtask

  task automatic test_late_sticky();
    logic [31:0] cap;
    int b_dlv;
    one_shot(-300, 32'hA5A5_0005, 1'b1, 1'b1, "R7");
    lead_off = 0;
    b_dlv = n_dlv;
    send(32'hA5A5_0006, cap);
    wait_tick(cap + 32'd260);
    #1;
    chk(lockstep_err == 1'b1, "R7", "sticky after good message", 64'(lockstep_err), 1);
    chk(n_dlv - b_dlv == 1, "R7", "later message delivered", 64'(n_dlv - b_dlv), 1);
    @(negedge clk);
    do_reset();
    chk(lockstep_err == 1'b0, "R9", "error cleared by reset", 64'(lockstep_err), 0);
  endtask

  task automatic test_order();
    logic [31:0] ca, cb, cc, cd, ce;
    int b;
    do_reset();
    b = n_dlv;
    lead_off = 0;
    send(32'h11, ca);
    send(32'h22, cb);
    send(32'h33, cc);
    wait_tick(ca + 32'd262);
    #1;
    chk(n_dlv - b == 3, "R2", "burst count", 64'(n_dlv - b), 3);
    chk(dlv_dat[b] == 32'h11 && dlv_dat[b+1] == 32'h22 && dlv_dat[b+2] == 32'h33,
        "R2", "burst order", 64'(dlv_dat[b+1]), 64'h22);
    chk(dlv_tick[b+2] == cc + 32'd256, "R4", "third due tick",
        64'(dlv_tick[b+2]), 64'(cc + 32'd256));
    @(negedge clk);
    b = n_dlv;
    lead_off = 10;
    send(32'h44, cd);
    lead_off = 0;
    send(32'h55, ce);
    wait_tick(cd + 32'd270);
    #1;
    chk(n_dlv - b == 2, "R5", "overlap count", 64'(n_dlv - b), 2);
    chk(dlv_tick[b] == cd + 32'd266 && dlv_dat[b] == 32'h44, "R5", "older first",
        64'(dlv_tick[b]), 64'(cd + 32'd266));
    chk(dlv_tick[b+1] == cd + 32'd267 && dlv_dat[b+1] == 32'h55, "R5",
        "younger next cycle", 64'(dlv_tick[b+1]), 64'(cd + 32'd267));
  endtask

  task automatic test_full_swap();
    logic [31:0] c0, cx;
    int b;
    do_reset();
    lead_off = 200;
    b = n_dlv;
    send(32'h100, c0);
    for (int i = 1; i < DEPTH + 1; i++) send(32'h100 + 32'(i), cx);
    src_valid = 1'b1;
    src_data = 32'hEE;
    #1;
    chk(src_ready == 1'b0, "R3", "input stalled", 64'(src_ready), 0);
    chk(q_full == 1'b1, "R3", "q_full", 64'(q_full), 1);
    chk(q_count == CNT_W'(DEPTH), "R3", "q_count", 64'(q_count), 64'(DEPTH));
    @(negedge clk);
    chk(src_ready == 1'b0 && q_count == CNT_W'(DEPTH), "R1", "stall holds",
        64'(src_ready), 0);
    wait_tick(c0 + 32'd456);
    chk(dlv_valid == 1'b1 && dlv_data == 32'h100, "R10", "head released",
        64'(dlv_data), 64'h100);
    chk(src_ready == 1'b1, "R10", "ready in release cycle", 64'(src_ready), 1);
    @(negedge clk);
    src_valid = 1'b0;
    chk(q_count == CNT_W'(DEPTH), "R10", "count held", 64'(q_count), 64'(DEPTH));
    chk(dlv_valid == 1'b1 && dlv_data == 32'h101, "R2", "next in order",
        64'(dlv_data), 64'h101);
    #1;
    chk(n_dlv - b == 2, "R5", "one per cycle", 64'(n_dlv - b), 2);
  endtask

  task automatic test_wrap();
    logic [31:0] cap;
    int b_dlv, b_warn;
    do_reset();
    load_tick(32'hFFFF_FF80);
    lead_off = 0;
    b_dlv = n_dlv;
    b_warn = n_warn;
    send(32'hBEEF, cap);
    wait_tick(cap + 32'd259);
    #1;
    chk(n_dlv - b_dlv == 1, "R8", "wrapped delivery count", 64'(n_dlv - b_dlv), 1);
    chk(dlv_tick[b_dlv] == cap + 32'd256, "R8", "wrapped tick",
        64'(dlv_tick[b_dlv]), 64'(cap + 32'd256));
    chk(n_warn == b_warn && lockstep_err == 1'b0, "R8", "no false flags",
        64'(lockstep_err), 0);
    @(negedge clk);
  endtask

  initial begin
    test_reset();
    test_on_time();
    test_margin();
    test_tight_edge();
    test_late_edge();
    test_late_sticky();
    test_order();
    test_full_swap();
    test_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule